// File: doc/BRIEF.md
# Integrity Metadata Set-Associative Cache

This block keeps recently verified integrity-tree nodes next to a memory encryption unit so that a tree walk can stop early. A walk controller sends it one request at a time. A lookup reports whether a node line is resident and returns its 64-byte contents. A fill installs a line that the controller has just fetched and verified, and it reports any line it had to displace. The default array is 128 sets of 8 ways, with one 64-byte line per way, for 64 KiB in total. Each node fills exactly one line.

The set a line lands in depends on its tree level. Leaf counter lines go to odd sets and the MAC tag lines that pair with them go to even sets. Because of this, the 8 leaf lines that cover one 4 KiB page (one leaf per 512 bytes) take 8 consecutive odd sets. Victims are picked by a 7-bit tree pseudo-LRU per set. Empty ways are used before any line is displaced.

Requests from outside the protected region leave the array untouched. So do flush commands meant for ordinary data caches.

Both streams use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears in the following cycle and is held unchanged until `rsp_ready` is high. `req_ready` is high whenever no response is waiting, or when the waiting response is being taken in the same cycle. So the caller can issue one request per cycle while it keeps `rsp_ready` high.

Top module: `imc_cache`

## Requirements
- R1: A synchronous reset clears every valid bit and drops `rsp_valid`. The first lookup after reset misses.
- R2: A lookup (req_op 2'b00) of a resident line returns rsp_hit=1 and the stored 512-bit line. A lookup of an absent line returns rsp_hit=0. Two ways of one set never both match.
- R3: A fill (req_op 2'b01) into a set that has an empty way uses the lowest-numbered empty way. It reports rsp_evict_valid=0, and the line is then resident.
- R4: When a fill misses in a full set, the pseudo-LRU victim is displaced, and its level and address are reported with rsp_evict_valid=1. Every hit and every fill makes the touched way most recent. After ways 0..7 are filled in order, the victim is way 0. After that fill and a hit on way 4, the victim is way 2.
- R5: A fill of a line that is already resident overwrites its data in place and displaces nothing.
- R6: A target line is evicted by filling 8 distinct lines that conflict with it in its set, then looking them up in reverse order. The target then misses.
- R7: Set index depends on req_level. Level 0 (MAC tag line) maps to set {addr[5:0],0}. Level 1 (leaf counter line) maps to {addr[5:0],1}. Any other level maps to addr[6:0]. Lines with the same address but different levels are separate entries.
- R8: A request with req_prot=0 misses, displaces nothing, and changes no state.
- R9: A data-cache line flush (req_op 2'b10) is accepted and answered with rsp_hit=0 and rsp_evict_valid=0. Every line stays resident.
- R10: While rsp_valid=1 and rsp_ready=0, all response fields hold still and req_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 00 lookup, 01 fill, 10 data-cache flush, 11 no operation |
| req_prot | input | 1 | Address lies in the protected region |
| req_level | input | 3 | Tree level: 0 MAC tag, 1 leaf counter, 2+ upper nodes |
| req_addr | input | 26 | Line address |
| req_data | input | 512 | Line contents for a fill |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_hit | output | 1 | Line was resident |
| rsp_data | output | 512 | Line contents on a lookup hit, zero otherwise |
| rsp_evict_valid | output | 1 | A fill displaced a valid line |
| rsp_evict_level | output | 3 | Level of the displaced line |
| rsp_evict_addr | output | 26 | Address of the displaced line |

## Verification
The assertions assume that `rsp_ready` and the request fields carry known values whenever `req_valid` is high. They also assume that a line is installed only by a fill that follows a miss for it, so a set never holds a duplicate tag. The bench follows both rules: it drives every field on the falling edge, it never fills two copies of one tag, and it uses distinct sets for the replacement, sweep and mapping scenarios so that the recency state in each set can be worked out by hand. Back-pressure is exercised by holding `rsp_ready` low for two cycles across a taken request.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int unsigned LVL_W = 3;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_FILL   = 2'b01,
    OP_DFLUSH = 2'b10,
    OP_NOP    = 2'b11
  } imc_op_e;

  localparam logic [LVL_W-1:0] LVL_MACTAG = 3'd0;
  localparam logic [LVL_W-1:0] LVL_LEAF   = 3'd1;
endpackage

// File: rtl/imc_set_map.sv
module imc_set_map
  import imc_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned SETS   = 128,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned TAG_W = LVL_W + ADDR_W
) (
  input  logic [LVL_W-1:0]  level,
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag
);
  // Leaf counters and their MAC tags share the low address bits but
  // are split by set parity; upper levels index directly.
  always_comb begin
    unique case (level)
      LVL_MACTAG: set_idx = {addr[SET_W-2:0], 1'b0};
      LVL_LEAF:   set_idx = {addr[SET_W-2:0], 1'b1};
      default:    set_idx = addr[SET_W-1:0];
    endcase
    tag = {level, addr};
  end
endmodule

// File: rtl/imc_tag_store.sv
module imc_tag_store #(
  parameter int unsigned SETS  = 128,
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 29,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic [WAY_W-1:0] sel_way,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             hit_any,
  output logic [WAY_W-1:0] hit_way,
  output logic             free_any,
  output logic [WAY_W-1:0] free_way,
  output logic [TAG_W-1:0] sel_tag
);
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [WAYS-1:0]           hit_vec;
  logic [WAYS-1:0]           row_valid;

  assign row_valid = valid_q[rd_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_valid[w] && (tag_q[rd_set][w] == cmp_tag);
  end

  always_comb begin
    hit_any  = |hit_vec;
    hit_way  = '0;
    free_any = ~&row_valid;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])    hit_way  = WAY_W'(w);
      if (!row_valid[w]) free_way = WAY_W'(w);
    end
  end

  assign sel_tag = tag_q[rd_set][sel_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R2

  AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_set)][$past(wr_way)]); // R3

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0)); // R1
endmodule

// File: rtl/imc_plru.sv
module imc_plru #(
  parameter int unsigned SETS = 128,
  parameter int unsigned WAYS = 8,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  // Node n has children 2n+1 (lower half) and 2n+2 (upper half).
  // A node bit of 0 steers the victim search to the lower half.
  logic [SETS-1:0][NODES-1:0] tree_q;
  logic [NODES-1:0]           row_rd;
  logic [NODES-1:0]           row_nx;

  assign row_rd = tree_q[rd_set];

  always_comb begin
    int node;
    victim_way = '0;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      victim_way[WAY_W-1-l] = row_rd[node];
      node = 2 * node + 1 + int'(row_rd[node]);
    end
  end

  always_comb begin
    int node;
    row_nx = tree_q[touch_set];
    for (int l = 0; l < WAY_W; l++) begin
      node = (1 << l) - 1 + int'(touch_way >> (WAY_W - l));
      row_nx[node] = ~touch_way[WAY_W-1-l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tree_q <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= row_nx;
    end
  end

  AST_TOUCH_NOT_VICTIM: assert property (@(posedge clk) disable iff (rst)
    (touch_en && rd_set == touch_set) |=>
      (rd_set != $past(touch_set)) || (victim_way != $past(touch_way))); // R4
endmodule

// File: rtl/imc_data_store.sv
module imc_data_store #(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned LINE_W  = 512,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_data
);
  logic [LINE_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/imc_cache.sv
module imc_cache
  import imc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 26,
  parameter int unsigned SETS       = 128,
  parameter int unsigned WAYS       = 8,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned TAG_W  = LVL_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_prot,
  input  logic [LVL_W-1:0]  req_level,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_evict_valid,
  output logic [LVL_W-1:0]  rsp_evict_level,
  output logic [ADDR_W-1:0] rsp_evict_addr
);
  imc_op_e          op;
  logic             fire, act, is_fill, is_lookup, touch, evict;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag, sel_tag;
  logic             hit_any, free_any;
  logic [WAY_W-1:0] hit_way, free_way, victim_way, fill_way, touch_way;
  logic [LINE_W-1:0] rd_line;

  assign op        = imc_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign act       = fire && req_prot && (op == OP_LOOKUP || op == OP_FILL);
  assign is_fill   = act && (op == OP_FILL);
  assign is_lookup = act && (op == OP_LOOKUP);

  imc_set_map #(.ADDR_W(ADDR_W), .SETS(SETS)) u_map (
    .level(req_level), .addr(req_addr), .set_idx(set_idx), .tag(req_tag)
  );

  imc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .rd_set(set_idx), .cmp_tag(req_tag),
    .sel_way(victim_way), .wr_en(is_fill), .wr_set(set_idx),
    .wr_way(fill_way), .wr_tag(req_tag), .hit_any(hit_any),
    .hit_way(hit_way), .free_any(free_any), .free_way(free_way),
    .sel_tag(sel_tag)
  );

  imc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst(rst), .rd_set(set_idx), .touch_en(touch),
    .touch_set(set_idx), .touch_way(touch_way), .victim_way(victim_way)
  );

  imc_data_store #(.ENTRIES(SETS * WAYS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .wr_en(is_fill), .wr_idx({set_idx, fill_way}),
    .wr_data(req_data), .rd_idx({set_idx, hit_way}), .rd_data(rd_line)
  );

  // Way choice: resident copy, then lowest empty way, then tree victim.
  always_comb begin
    if (hit_any)       fill_way = hit_way;
    else if (free_any) fill_way = free_way;
    else               fill_way = victim_way;
  end

  assign touch     = is_fill || (is_lookup && hit_any);
  assign touch_way = is_fill ? fill_way : hit_way;
  assign evict     = is_fill && !hit_any && !free_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_hit         <= 1'b0;
      rsp_data        <= '0;
      rsp_evict_valid <= 1'b0;
      rsp_evict_level <= '0;
      rsp_evict_addr  <= '0;
    end else if (fire) begin
      rsp_valid       <= 1'b1;
      rsp_hit         <= act && hit_any;
      rsp_data        <= (is_lookup && hit_any) ? rd_line : '0;
      rsp_evict_valid <= evict;
      rsp_evict_level <= evict ? sel_tag[TAG_W-1 -: LVL_W] : '0;
      rsp_evict_addr  <= evict ? sel_tag[ADDR_W-1:0] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
      && $stable(rsp_evict_valid) && $stable(rsp_evict_addr))); // R10

  AST_EVICT_ONLY_FILL: assert property (@(posedge clk) disable iff (rst)
    (fire && op != OP_FILL) |=> !rsp_evict_valid); // R4

  AST_UNPROT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fire && !req_prot) |=> (!rsp_hit && !rsp_evict_valid)); // R8

  AST_DFLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_DFLUSH) |=> (!rsp_hit && !rsp_evict_valid)); // R9
endmodule

// File: tb/test_imc_cache.sv
module test_imc_cache;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'b00;
  logic         req_prot = 1'b0;
  logic [2:0]   req_level = '0;
  logic [25:0]  req_addr = '0;
  logic [511:0] req_data = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic         rsp_hit;
  logic [511:0] rsp_data;
  logic         rsp_evict_valid;
  logic [2:0]   rsp_evict_level;
  logic [25:0]  rsp_evict_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic         r_hit, r_ev;
  logic [511:0] r_data;
  logic [2:0]   r_evlvl;
  logic [25:0]  r_evaddr;

  imc_cache i_imc_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_prot(req_prot), .req_level(req_level),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .rsp_evict_valid(rsp_evict_valid), .rsp_evict_level(rsp_evict_level),
    .rsp_evict_addr(rsp_evict_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [511:0] pat(input logic [25:0] a,
                                       input logic [2:0] l,
                                       input logic [7:0] s);
    return {16{s, 5'b0, l, a[15:0]}};
  endfunction

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [25:0] a,
                        input logic [2:0] l, input logic prot,
                        input logic [7:0] seed);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_level = l;
    req_prot = prot; req_data = pat(a, l, seed); rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_hit = rsp_hit; r_data = rsp_data; r_ev = rsp_evict_valid;
    r_evlvl = rsp_evict_level; r_evaddr = rsp_evict_addr;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid low after reset", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready high after reset", 64'(req_ready), 64'd1);
    do_req(2'b00, 26'd0, 3'd1, 1'b1, 8'd0);
    chk("R1 first lookup misses", 64'(r_hit), 64'd0);
  endtask

  task automatic t_fill_free();
    for (int k = 0; k < 8; k++) begin
      do_req(2'b01, 26'(64 * k), 3'd1, 1'b1, 8'd1);
      chk("R3 fill into empty way no evict", 64'(r_ev), 64'd0);
    end
    for (int k = 0; k < 8; k++) begin
      do_req(2'b00, 26'(64 * k), 3'd1, 1'b1, 8'd0);
      chk("R2 lookup hit", 64'(r_hit), 64'd1);
      chk("R2 lookup data", 64'(r_data == pat(26'(64 * k), 3'd1, 8'd1)), 64'd1);
    end
  endtask

  task automatic t_plru();
    do_req(2'b01, 26'd512, 3'd1, 1'b1, 8'd1);
    chk("R4 full set evicts", 64'(r_ev), 64'd1);
    chk("R4 victim is oldest fill", 64'(r_evaddr), 64'd0);
    chk("R4 victim level", 64'(r_evlvl), 64'd1);
    do_req(2'b00, 26'd256, 3'd1, 1'b1, 8'd0);
    chk("R4 hit on way 4", 64'(r_hit), 64'd1);
    do_req(2'b01, 26'd576, 3'd1, 1'b1, 8'd1);
    chk("R4 victim after hit is way 2", 64'(r_evaddr), 64'd128);
    do_req(2'b00, 26'd0, 3'd1, 1'b1, 8'd0);
    chk("R2 evicted line misses", 64'(r_hit), 64'd0);
  endtask

  task automatic t_map();
    do_req(2'b01, 26'd0, 3'd0, 1'b1, 8'd3);
    chk("R7 MAC tag line goes to even set", 64'(r_ev), 64'd0);
    do_req(2'b00, 26'd0, 3'd0, 1'b1, 8'd0);
    chk("R7 MAC tag line data", 64'(r_data == pat(26'd0, 3'd0, 8'd3)), 64'd1);
    do_req(2'b00, 26'd512, 3'd0, 1'b1, 8'd0);
    chk("R7 level is part of the tag", 64'(r_hit), 64'd0);
    do_req(2'b01, 26'd1, 3'd2, 1'b1, 8'd3);
    chk("R7 upper level shares leaf set", 64'(r_ev), 64'd1);
    chk("R7 upper level victim addr", 64'(r_evaddr), 64'd384);
    do_req(2'b00, 26'd512, 3'd1, 1'b1, 8'd0);
    chk("R7 leaf still resident", 64'(r_hit), 64'd1);
  endtask

  task automatic t_refill();
    do_req(2'b01, 26'd64, 3'd1, 1'b1, 8'd2);
    chk("R5 refill no evict", 64'(r_ev), 64'd0);
    do_req(2'b00, 26'd64, 3'd1, 1'b1, 8'd0);
    chk("R5 refill data updated", 64'(r_data == pat(26'd64, 3'd1, 8'd2)), 64'd1);
  endtask

  task automatic t_sweep();
    do_req(2'b01, 26'd1, 3'd1, 1'b1, 8'd4);
    for (int k = 1; k <= 8; k++) begin
      do_req(2'b01, 26'(1 + 64 * k), 3'd1, 1'b1, 8'd4);
      if (k == 8) chk("R6 eighth conflict evicts target", 64'(r_evaddr), 64'd1);
    end
    for (int k = 8; k >= 1; k--) begin
      do_req(2'b00, 26'(1 + 64 * k), 3'd1, 1'b1, 8'd0);
      chk("R6 backward pass hits", 64'(r_hit), 64'd1);
    end
    do_req(2'b00, 26'd1, 3'd1, 1'b1, 8'd0);
    chk("R6 target evicted", 64'(r_hit), 64'd0);
  endtask

  task automatic t_unprot();
    do_req(2'b00, 26'd64, 3'd1, 1'b0, 8'd0);
    chk("R8 unprotected lookup misses", 64'(r_hit), 64'd0);
    do_req(2'b01, 26'd1000, 3'd2, 1'b0, 8'd5);
    chk("R8 unprotected fill no evict", 64'(r_ev), 64'd0);
    do_req(2'b00, 26'd1000, 3'd2, 1'b1, 8'd0);
    chk("R8 unprotected fill not installed", 64'(r_hit), 64'd0);
  endtask

  task automatic t_dflush();
    do_req(2'b10, 26'd64, 3'd1, 1'b1, 8'd0);
    chk("R9 flush reports no hit", 64'(r_hit), 64'd0);
    chk("R9 flush no evict", 64'(r_ev), 64'd0);
    do_req(2'b00, 26'd64, 3'd1, 1'b1, 8'd0);
    chk("R9 line survives flush", 64'(r_hit), 64'd1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_op = 2'b00;
    req_addr = 26'd64; req_level = 3'd1; req_prot = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 response present", 64'(rsp_valid), 64'd1);
    chk("R10 ready low while stalled", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R10 response held", 64'(rsp_valid), 64'd1);
    chk("R10 hit held", 64'(rsp_hit), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 response drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    apply_reset();
    t_reset();
    t_fill_free();
    t_plru();
    t_map();
    t_refill();
    t_sweep();
    t_unprot();
    t_dflush();
    t_backpressure();
    apply_reset();
    do_req(2'b00, 26'd64, 3'd1, 1'b1, 8'd0);
    chk("R1 reset mid-run clears lines", 64'(r_hit), 64'd0);
    finish_run();
  end
endmodule